// File: doc/BRIEF.md
# Oscillator Counter Array Scan-Out

This block holds one event counter per ring-oscillator input. The oscillators belong to four groups: for each of two stress polarities there is a stress-sensitive and a stress-insensitive variant. All counters are cleared together and then count during one shared enable window. Each counter sees the rising edges of its own oscillator. The oscillator inputs are asynchronous to the system clock, so each one passes through a two-flop synchronizer and a rising-edge detector before it reaches its counter.

When the window has closed, a shift request turns the counters into one serial chain. The stored results leave on a single data pin, framed by a valid strobe. The per-group count is a parameter: a full-scale chip has 840 oscillators per group, and the default here is smaller so that elaboration stays light. Converting counts into device-level quantities is left to software downstream.

Top module: `osc_scan_array`

## Requirements
- R1: Each oscillator input has its own CNT_W-bit counter (16 bits by default). While cnt_en_i is high and no frame is in progress, each rising edge on that input, after the two-flop synchronizer, adds exactly one to that counter.
- R2: While cnt_en_i is low, edges on the oscillator inputs leave every counter and overflow flag unchanged.
- R3: A one-cycle pulse on clr_i outside a frame zeroes every counter and every overflow flag on the next clock edge.
- R4: A counter that increments past 2^CNT_W-1 wraps to zero and sets its overflow flag. The flag stays set through later increments until a clear or a readout.
- R5: A shift request starts a frame on the next clock edge. A shift request is shift_en_i high for one cycle while cnt_en_i is low and no frame is running. frame_vld_o is then high for exactly 4*GRP_N*(CNT_W+1) consecutive cycles. After reset, frame_vld_o and sdo_o are 0.
- R6: During a frame, sdo_o carries one chain bit per cycle. Counter 0 comes first and the rest follow in ascending index order. Each counter contributes its overflow flag and then its count, most significant bit first.
- R7: A shift request is ignored while cnt_en_i is high, and also while a frame is already running.
- R8: Readout is destructive, so every counter and flag holds zero after a complete frame. While a frame runs, clr_i, cnt_en_i and oscillator edges do not alter the bits that are shifted out.
- R9: Oscillator group g (0: polarity A sensitive, 1: polarity A insensitive, 2: polarity B sensitive, 3: polarity B insensitive), member k, is input bit osc_i[g*GRP_N+k], and it is also counter g*GRP_N+k in the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_i | input | 4*GRP_N | Asynchronous ring-oscillator signals |
| cnt_en_i | input | 1 | Counting window enable |
| clr_i | input | 1 | Synchronous clear of all counters |
| shift_en_i | input | 1 | Shift request pulse |
| sdo_o | output | 1 | Serial chain data |
| frame_vld_o | output | 1 | High while chain bits are on sdo_o |

## Verification
The bench drives counts just below and just above the wrap point. A counter that failed to wrap, or that dropped its overflow flag after wrapping, would return a wrong count or a zero flag. It issues shift requests during the counting window and in the middle of a frame. A sequencer that accepted either request would lengthen or restart the frame, and the bit count would not match. It also pulses clear and toggles the oscillators during a frame. If these were not gated, the streamed values would be corrupted. A second readout without a new window must return all zeros, which exposes a chain that is not refilled with zeros.

// File: rtl/osc_scan_pkg.sv
package osc_scan_pkg;
  localparam int unsigned N_GROUPS = 4;

  function automatic int unsigned chain_len(input int unsigned n_cells, input int unsigned cnt_w);
    return n_cells * (cnt_w + 1);
  endfunction
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], osc_i};
  end

  // sync_q[1] is the second synchronizer flop, sync_q[2] its delayed copy
  assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/osc_cnt_cell.sv
module osc_cnt_cell #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  input  logic shift_i,
  input  logic sin_i,
  output logic sout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (shift_i) begin
      {ovf_q, cnt_q} <= {cnt_q, sin_i};
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) ovf_q <= 1'b1;
    end
  end

  assign sout_o = ovf_q;

  // R1
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && !shift_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i && !shift_i |=> $stable(cnt_q) && $stable(ovf_q));
  // R3
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !shift_i |=> cnt_q == '0 && !ovf_q);
  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && !shift_i && (&cnt_q) |=> cnt_q == '0 && ovf_q);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !clr_i && !shift_i |=> ovf_q);
endmodule

// File: rtl/osc_scan_seq.sv
module osc_scan_seq #(
  parameter int unsigned CHAIN_LEN = 68
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_en_i,
  input  logic shift_en_i,
  output logic busy_o
);
  localparam int unsigned LEN_W = $clog2(CHAIN_LEN + 1);

  logic             busy_q;
  logic [LEN_W-1:0] bit_cnt_q;
  logic             start;

  assign start = shift_en_i & ~cnt_en_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      bit_cnt_q <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      bit_cnt_q <= '0;
    end else if (busy_q) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      if (bit_cnt_q == LEN_W'(CHAIN_LEN - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;

  // R7
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(shift_en_i) && !$past(cnt_en_i));
  // R5
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(bit_cnt_q) == LEN_W'(CHAIN_LEN - 1));
  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> bit_cnt_q < LEN_W'(CHAIN_LEN));
endmodule

// File: rtl/osc_scan_array.sv
module osc_scan_array
  import osc_scan_pkg::*;
#(
  parameter int unsigned GRP_N = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_GROUPS*GRP_N-1:0] osc_i,
  input  logic                      cnt_en_i,
  input  logic                      clr_i,
  input  logic                      shift_en_i,
  output logic                      sdo_o,
  output logic                      frame_vld_o
);
  localparam int unsigned N_OSC     = N_GROUPS * GRP_N;
  localparam int unsigned CHAIN_LEN = chain_len(N_OSC, CNT_W);

  logic             busy;
  logic [N_OSC-1:0] rise;
  logic [N_OSC:0]   chain;

  osc_scan_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en_i),
    .shift_en_i (shift_en_i),
    .busy_o     (busy)
  );

  assign chain[N_OSC] = 1'b0;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < GRP_N; k++) begin : g_osc
      localparam int unsigned IDX = g * GRP_N + k;

      osc_edge_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .osc_i  (osc_i[IDX]),
        .rise_o (rise[IDX])
      );

      osc_cnt_cell #(.CNT_W(CNT_W)) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (rise[IDX] & cnt_en_i & ~busy),
        .clr_i   (clr_i & ~busy),
        .shift_i (busy),
        .sin_i   (chain[IDX+1]),
        .sout_o  (chain[IDX])
      );
    end
  end

  assign sdo_o       = chain[0];
  assign frame_vld_o = busy;

  // R7
  no_start_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_o && cnt_en_i |=> !frame_vld_o);
endmodule

// File: tb/tb_osc_scan_array.sv
module tb_osc_scan_array;
  localparam int unsigned GRP_N = 2;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned N_OSC = 4 * GRP_N;
  localparam int unsigned TOT   = N_OSC * (CNT_W + 1);
  localparam int unsigned MODV  = 1 << CNT_W;
  localparam int unsigned NV    = 5;

  localparam int unsigned PULSES [NV][N_OSC] = '{
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{255, 0, 17, 128, 1, 200, 64, 3},
    '{256, 257, 0, 300, 9, 255, 511, 2},
    '{5, 0, 5, 0, 5, 0, 5, 0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_OSC-1:0] osc = '0;
  logic cnt_en = 1'b0, clr = 1'b0, shift_en = 1'b0;
  logic sdo, frame_vld;

  int unsigned cur_p [N_OSC];
  logic rx [TOT];
  int nbits;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  osc_scan_array #(.GRP_N(GRP_N), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_i(osc), .cnt_en_i(cnt_en),
    .clr_i(clr), .shift_en_i(shift_en), .sdo_o(sdo), .frame_vld_o(frame_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_pulses();
    int unsigned maxp = 0;
    for (int k = 0; k < N_OSC; k++) if (cur_p[k] > maxp) maxp = cur_p[k];
    for (int unsigned s = 0; s < maxp; s++) begin
      @(negedge clk);
      for (int k = 0; k < N_OSC; k++) osc[k] = (cur_p[k] > s);
      repeat (2) @(negedge clk);
      osc = '0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic window();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; cnt_en = 1'b1;
    drive_pulses();
    cnt_en = 1'b0;
  endtask

  task automatic read_frame(input bit disturb);
    @(negedge clk); shift_en = 1'b1;
    @(negedge clk); shift_en = 1'b0;
    nbits = 0;
    while (frame_vld && nbits < 2 * TOT) begin
      if (nbits < TOT) rx[nbits] = sdo;
      if (disturb) begin
        if (nbits == 20) begin clr = 1'b1; shift_en = 1'b1; cnt_en = 1'b1; osc = '1; end
        if (nbits == 21) begin clr = 1'b0; shift_en = 1'b0; end
        if (nbits == 24) osc = '0;
        if (nbits == 26) osc = '1;
        if (nbits == 30) begin cnt_en = 1'b0; osc = '0; end
      end
      nbits++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input string tag, input bit zero);
    check("R5 frame length", nbits, TOT);
    for (int i = 0; i < N_OSC; i++) begin
      int unsigned e = zero ? 0 : cur_p[i];
      int v = 0;
      int ovf = rx[i*(CNT_W+1)];
      for (int j = 1; j <= CNT_W; j++) v = (v << 1) | int'(rx[i*(CNT_W+1)+j]);
      check({tag, " count"}, v, int'(e % MODV));
      check("R4 overflow flag", ovf, int'(e >= MODV));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check("R5 reset frame_vld", int'(frame_vld), 0);
    check("R5 reset sdo", int'(sdo), 0);
    rst_ni = 1'b1;

    // vector table: R1 R4 R6 R9
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < N_OSC; k++) cur_p[k] = PULSES[v][k];
      window();
      read_frame(1'b0);
      check_frame("R1/R6", 1'b0);
    end

    // R7: request during counting window ignored
    @(negedge clk); cnt_en = 1'b1; shift_en = 1'b1;
    @(negedge clk); shift_en = 1'b0;
    hi = 0;
    repeat (10) begin if (frame_vld) hi++; @(negedge clk); end
    check("R7 request while counting", hi, 0);
    cnt_en = 1'b0;

    // R2: pulses with counting disabled leave counts intact
    cur_p = '{3, 1, 4, 1, 5, 9, 2, 6};
    window();
    drive_pulses();
    read_frame(1'b0);
    check_frame("R2", 1'b0);

    // R8: destructive readout
    read_frame(1'b0);
    check_frame("R8 second read", 1'b1);

    // R3: clear wipes counts and overflow
    cur_p = '{260, 7, 0, 1, 255, 256, 12, 99};
    window();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    read_frame(1'b0);
    check_frame("R3", 1'b1);

    // R8 + R9: disturbance mid-frame, per-group distinct values
    for (int g = 0; g < 4; g++)
      for (int k = 0; k < GRP_N; k++) cur_p[g*GRP_N+k] = g * 10 + k + 1;
    window();
    read_frame(1'b1);
    check_frame("R9/R8", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule